// File: doc/BRIEF.md
# Soft Register Exchange Reliability Update

This block refreshes the stored reliabilities along one survivor history of a soft-output register exchange. Each cycle it receives the history of the winning predecessor path and the history of the second-most-likely predecessor path. Every history entry is a hard bit decision plus a magnitude. It also receives the reliability of the current compare-select decision. For each history position and each bit of the symbol, the block limits the winner's magnitude by a bound. When the two paths disagree on that bit, the bound is the decision reliability. When they agree, the bound is the decision reliability plus the second path's own magnitude, saturated.

The winner's hard decisions pass through unchanged, and the whole history moves one position older. The freshly generated initial LLR enters as the newest position. The updated entry that leaves at the oldest position is converted from sign-magnitude form to a two's complement LLR and presented with a valid flag. All history positions are updated in parallel by identical cells, and the result is registered once.

Top module: `srx_rel_update`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first valid input, `upd_dec`, `upd_mag` and `out_llr` are zero and `out_valid` is low.
- R2: When the winner and second path hold different bit decisions at a position, the updated magnitude is the smaller of the winner's magnitude and `dec_rel`.
- R3: When the two paths hold the same bit decision at a position, the updated magnitude is the smaller of the winner's magnitude and `dec_rel + sec_mag`, where the sum saturates at 2^MAG_W-1 before the minimum is taken.
- R4: The updated entry of history position p appears at position p+1 of `upd_dec`/`upd_mag` one clock after the `in_valid` cycle. Its decision bit equals the winner's decision bit at position p.
- R5: One clock after an `in_valid` cycle, position 0 of `upd_dec`/`upd_mag` holds `new_dec`/`new_mag` exactly.
- R6: One clock after an `in_valid` cycle, `out_valid` is high and bit b of the symbol appears in `out_llr` slice b (MAG_W+1 bits) as a two's complement value. That value is the updated magnitude of the oldest winner position, negated when the winner's decision bit there is 1 and positive when it is 0. One clock after a cycle without `in_valid`, `out_valid` is low.
- R7: In a cycle with `in_valid` low, `upd_dec`, `upd_mag` and `out_llr` keep their values whatever the other inputs do.
- R8: Position 0 is the newest entry. Bit b of position p sits at flat index p*BITS_PER_SYM+b of a decision vector, and its magnitude sits at bits [(p*BITS_PER_SYM+b)*MAG_W +: MAG_W] of a magnitude vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs carry an update this cycle |
| dec_rel | input | MAG_W | Reliability of the current compare-select decision |
| win_dec | input | HIST_LEN*BITS_PER_SYM | Winner path bit decisions |
| win_mag | input | HIST_LEN*BITS_PER_SYM*MAG_W | Winner path magnitudes |
| sec_dec | input | HIST_LEN*BITS_PER_SYM | Second path bit decisions |
| sec_mag | input | HIST_LEN*BITS_PER_SYM*MAG_W | Second path magnitudes |
| new_dec | input | BITS_PER_SYM | Bit decisions of the fresh initial LLR |
| new_mag | input | BITS_PER_SYM*MAG_W | Magnitudes of the fresh initial LLR |
| upd_dec | output | HIST_LEN*BITS_PER_SYM | Shifted, updated history decisions |
| upd_mag | output | HIST_LEN*BITS_PER_SYM*MAG_W | Shifted, updated history magnitudes |
| out_valid | output | 1 | `out_llr` carries a new value |
| out_llr | output | BITS_PER_SYM*(MAG_W+1) | Oldest entry as two's complement LLRs |

## Verification
A hand-computed table puts each case at every position together. The cases are disagreeing bits where the decision reliability or the winner's magnitude is the smaller value, agreeing bits where the unsaturated sum or the winner wins, and sums past the maximum magnitude that must clip at 127 instead of wrapping. These cases separate a swapped bound choice, a missing saturation and a swapped minimum. Random histories are then checked against an independent model, and they catch a misplaced shift or a wrong field offset. Directed steps cover reset, the hold on an idle cycle, and the sign of the exported LLR for both decision values.

// File: rtl/srx_pkg.sv
package srx_pkg;
   // Which bound a reliability cell applies to its entry.
   typedef enum logic {
      BND_DECISION = 1'b0,  // paths disagree: decision reliability alone
      BND_SUM      = 1'b1   // paths agree: decision reliability + second magnitude
   } bound_sel_e;

   localparam int unsigned DEF_HIST_LEN = 8;
   localparam int unsigned DEF_BPS      = 2;
   localparam int unsigned DEF_MAG_W    = 7;
endpackage

// File: rtl/srx_rel_cell.sv
module srx_rel_cell
   import srx_pkg::*;
#(
   parameter int unsigned MAG_W    = DEF_MAG_W,
   parameter bit          WIDE_CMP = 1'b0
) (
   input  logic             win_bit,
   input  logic             sec_bit,
   input  logic [MAG_W-1:0] win_mag,
   input  logic [MAG_W-1:0] sec_mag,
   input  logic [MAG_W-1:0] dec_rel,
   output logic [MAG_W-1:0] upd_mag
);
   bound_sel_e       sel;
   logic [MAG_W:0]   sum_w;

   assign sel   = (win_bit == sec_bit) ? BND_SUM : BND_DECISION;
   assign sum_w = {1'b0, dec_rel} + {1'b0, sec_mag};

   generate
      if (WIDE_CMP) begin : g_wide
         // Compare one bit wider; the minimum never exceeds win_mag, so it fits.
         logic [MAG_W:0] bound_w;
         assign bound_w = (sel == BND_SUM) ? sum_w : {1'b0, dec_rel};
         assign upd_mag = ({1'b0, win_mag} < bound_w) ? win_mag : bound_w[MAG_W-1:0];
      end else begin : g_sat
         logic [MAG_W-1:0] sum_sat;
         logic [MAG_W-1:0] bound;
         assign sum_sat = sum_w[MAG_W] ? {MAG_W{1'b1}} : sum_w[MAG_W-1:0];
         assign bound   = (sel == BND_SUM) ? sum_sat : dec_rel;
         assign upd_mag = (win_mag < bound) ? win_mag : bound;
      end
   endgenerate
endmodule

// File: rtl/srx_sm2tc.sv
module srx_sm2tc
   import srx_pkg::*;
#(
   parameter int unsigned MAG_W = DEF_MAG_W
) (
   input  logic             sgn,
   input  logic [MAG_W-1:0] mag,
   output logic [MAG_W:0]   tc
);
   logic [MAG_W:0] ext;
   assign ext = {1'b0, mag};
   assign tc  = sgn ? (~ext + {{MAG_W{1'b0}}, 1'b1}) : ext;
endmodule

// File: rtl/srx_rel_update.sv
module srx_rel_update
   import srx_pkg::*;
#(
   parameter int unsigned HIST_LEN     = DEF_HIST_LEN,
   parameter int unsigned BITS_PER_SYM = DEF_BPS,
   parameter int unsigned MAG_W        = DEF_MAG_W,
   parameter bit          WIDE_CMP     = 1'b0
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    in_valid,
   input  logic [MAG_W-1:0]                        dec_rel,
   input  logic [HIST_LEN*BITS_PER_SYM-1:0]        win_dec,
   input  logic [HIST_LEN*BITS_PER_SYM*MAG_W-1:0]  win_mag,
   input  logic [HIST_LEN*BITS_PER_SYM-1:0]        sec_dec,
   input  logic [HIST_LEN*BITS_PER_SYM*MAG_W-1:0]  sec_mag,
   input  logic [BITS_PER_SYM-1:0]                 new_dec,
   input  logic [BITS_PER_SYM*MAG_W-1:0]           new_mag,
   output logic [HIST_LEN*BITS_PER_SYM-1:0]        upd_dec,
   output logic [HIST_LEN*BITS_PER_SYM*MAG_W-1:0]  upd_mag,
   output logic                                    out_valid,
   output logic [BITS_PER_SYM*(MAG_W+1)-1:0]       out_llr
);
   localparam int unsigned ENTRIES = HIST_LEN * BITS_PER_SYM;
   localparam int unsigned SHIFT_N = (HIST_LEN - 1) * BITS_PER_SYM;
   localparam int unsigned LLR_W   = MAG_W + 1;

   generate
      if (HIST_LEN < 2) begin : g_chk_len
         $error("srx_rel_update: HIST_LEN must be at least 2");
      end
      if (BITS_PER_SYM < 1) begin : g_chk_bps
         $error("srx_rel_update: BITS_PER_SYM must be at least 1");
      end
      if (MAG_W < 2) begin : g_chk_mag
         $error("srx_rel_update: MAG_W must be at least 2");
      end
   endgenerate

   logic [ENTRIES*MAG_W-1:0]      cell_mag;
   logic [BITS_PER_SYM*LLR_W-1:0] llr_nxt;

   // One bound cell per history entry, all in parallel.
   generate
      for (genvar k = 0; k < ENTRIES; k++) begin : g_cell
         srx_rel_cell #(.MAG_W(MAG_W), .WIDE_CMP(WIDE_CMP)) u_cell (
            .win_bit (win_dec[k]),
            .sec_bit (sec_dec[k]),
            .win_mag (win_mag[k*MAG_W +: MAG_W]),
            .sec_mag (sec_mag[k*MAG_W +: MAG_W]),
            .dec_rel (dec_rel),
            .upd_mag (cell_mag[k*MAG_W +: MAG_W])
         );
      end
      // The oldest position leaves the history as two's complement.
      for (genvar b = 0; b < BITS_PER_SYM; b++) begin : g_conv
         srx_sm2tc #(.MAG_W(MAG_W)) u_conv (
            .sgn (win_dec[SHIFT_N + b]),
            .mag (cell_mag[(SHIFT_N + b)*MAG_W +: MAG_W]),
            .tc  (llr_nxt[b*LLR_W +: LLR_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_dec   <= '0;
         upd_mag   <= '0;
         out_llr   <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            upd_dec <= {win_dec[SHIFT_N-1:0], new_dec};
            upd_mag <= {cell_mag[SHIFT_N*MAG_W-1:0], new_mag};
            out_llr <= llr_nxt;
         end
      end
   end

   // ---------------- assertions ----------------
   generate
      for (genvar k = 0; k < SHIFT_N; k++) begin : g_ast
         // R2: disagreeing bits are limited by the decision reliability
         a_r2_disagree_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (win_dec[k] != sec_dec[k])) |=>
               ((upd_mag[(k+BITS_PER_SYM)*MAG_W +: MAG_W] <= $past(dec_rel)) &&
                (upd_mag[(k+BITS_PER_SYM)*MAG_W +: MAG_W] <= $past(win_mag[k*MAG_W +: MAG_W]))));
         // R3: agreeing bits never grow and never drop below the decision reliability floor
         a_r3_agree_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (win_dec[k] == sec_dec[k])) |=>
               ((upd_mag[(k+BITS_PER_SYM)*MAG_W +: MAG_W] <= $past(win_mag[k*MAG_W +: MAG_W])) &&
                ((upd_mag[(k+BITS_PER_SYM)*MAG_W +: MAG_W] >= $past(dec_rel)) ||
                 (upd_mag[(k+BITS_PER_SYM)*MAG_W +: MAG_W] == $past(win_mag[k*MAG_W +: MAG_W])))));
         // R4: decisions move one position older unchanged
         a_r4_dec_shift: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (upd_dec[k+BITS_PER_SYM] == $past(win_dec[k])));
      end
   endgenerate

   // R5: newest position takes the fresh entry
   a_r5_newest: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((upd_mag[BITS_PER_SYM*MAG_W-1:0] == $past(new_mag)) &&
                    (upd_dec[BITS_PER_SYM-1:0] == $past(new_dec))));
   // R6: output valid follows input valid by one cycle
   a_r6_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r6_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R7: idle cycles leave the history and output untouched
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(upd_mag) && $stable(upd_dec) && $stable(out_llr)));
endmodule

// File: tb/sim_srx_rel_update.sv
module sim_srx_rel_update;
   localparam int L  = 8;
   localparam int B  = 2;
   localparam int M  = 7;
   localparam int E  = L * B;
   localparam int MX = (1 << M) - 1;
   localparam int NV = 12;

   // {win_bit, sec_bit, win_mag, sec_mag, dec_rel, expected}
   localparam logic [29:0] VEC [NV] = '{
      {1'b0, 1'b1, 7'd50,  7'd10,  7'd20,  7'd20 },
      {1'b0, 1'b1, 7'd10,  7'd10,  7'd20,  7'd10 },
      {1'b1, 1'b1, 7'd50,  7'd10,  7'd20,  7'd30 },
      {1'b1, 1'b1, 7'd25,  7'd10,  7'd20,  7'd25 },
      {1'b0, 1'b0, 7'd127, 7'd100, 7'd100, 7'd127},
      {1'b0, 1'b0, 7'd120, 7'd100, 7'd100, 7'd120},
      {1'b1, 1'b0, 7'd127, 7'd127, 7'd127, 7'd127},
      {1'b0, 1'b0, 7'd0,   7'd5,   7'd5,   7'd0  },
      {1'b1, 1'b0, 7'd90,  7'd0,   7'd0,   7'd0  },
      {1'b0, 1'b0, 7'd127, 7'd127, 7'd127, 7'd127},
      {1'b1, 1'b1, 7'd127, 7'd64,  7'd63,  7'd127},
      {1'b0, 1'b0, 7'd127, 7'd64,  7'd62,  7'd126}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid;
   logic [M-1:0]     dec_rel;
   logic [E-1:0]     win_dec, sec_dec, upd_dec;
   logic [E*M-1:0]   win_mag, sec_mag, upd_mag;
   logic [B-1:0]     new_dec;
   logic [B*M-1:0]   new_mag;
   logic             out_valid;
   logic [B*(M+1)-1:0] out_llr;

   logic [E-1:0]     exp_dec;
   logic [E*M-1:0]   exp_mag;
   logic [B*(M+1)-1:0] exp_llr;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;  // 50 MHz

   srx_rel_update u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec_rel(dec_rel),
      .win_dec(win_dec), .win_mag(win_mag), .sec_dec(sec_dec), .sec_mag(sec_mag),
      .new_dec(new_dec), .new_mag(new_mag), .upd_dec(upd_dec), .upd_mag(upd_mag),
      .out_valid(out_valid), .out_llr(out_llr)
   );

   function automatic logic [M-1:0] bound_model(logic wd, logic sd, int wm, int sm, int dr);
      int lim;
      if (wd != sd) lim = dr;
      else begin
         lim = dr + sm;
         if (lim > MX) lim = MX;
      end
      return (wm < lim) ? M'(wm) : M'(lim);
   endfunction

   // Expected outputs from the current inputs, per the requirements.
   task automatic predict();
      logic [M-1:0] m;
      exp_dec = {win_dec[E-B-1:0], new_dec};
      exp_mag[B*M-1:0] = new_mag;
      for (int k = 0; k < E; k++) begin
         m = bound_model(win_dec[k], sec_dec[k], int'(win_mag[k*M +: M]),
                         int'(sec_mag[k*M +: M]), int'(dec_rel));
         if (k < E - B) exp_mag[(k+B)*M +: M] = m;
         else exp_llr[(k-(E-B))*(M+1) +: M+1] =
                 win_dec[k] ? (M+1)'(-int'(m)) : (M+1)'(int'(m));
      end
   endtask

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic randomize_inputs();
      for (int k = 0; k < E; k++) begin
         win_dec[k] = 1'($urandom);
         sec_dec[k] = 1'($urandom);
         win_mag[k*M +: M] = M'($urandom_range(0, MX));
         sec_mag[k*M +: M] = M'($urandom_range(0, MX));
      end
      dec_rel = M'($urandom_range(0, MX));
      new_dec = B'($urandom);
      new_mag = (B*M)'($urandom);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: run did not end, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [E-1:0]     sv_dec;
      logic [E*M-1:0]   sv_mag;
      logic [B*(M+1)-1:0] sv_llr;
      rst_n = 1'b0; in_valid = 1'b0;
      randomize_inputs();
      repeat (3) step();
      // R1: reset state, also during reset with inputs active
      in_valid = 1'b1;
      step();
      check("R1 upd_mag", 128'(upd_mag), 128'(0));
      check("R1 upd_dec", 128'(upd_dec), 128'(0));
      check("R1 out_llr/out_valid", 128'({out_llr, out_valid}), 128'(0));
      in_valid = 1'b0;
      rst_n = 1'b1;
      step();
      check("R1 after release", 128'({upd_dec, out_valid}), 128'(0));

      // Table walk: same case at every position.
      for (int v = 0; v < NV; v++) begin
         logic [E*M-1:0] em;
         logic [B*(M+1)-1:0] el;
         for (int k = 0; k < E; k++) begin
            win_dec[k] = VEC[v][29];
            sec_dec[k] = VEC[v][28];
            win_mag[k*M +: M] = VEC[v][27:21];
            sec_mag[k*M +: M] = VEC[v][20:14];
         end
         dec_rel = VEC[v][13:7];
         new_dec = B'(v);
         new_mag = (B*M)'(v * 37 + 5);
         in_valid = 1'b1;
         em = '0;
         em[B*M-1:0] = new_mag;
         for (int k = B; k < E; k++) em[k*M +: M] = VEC[v][6:0];
         for (int b = 0; b < B; b++)
            el[b*(M+1) +: M+1] = VEC[v][29] ? (M+1)'(-int'(VEC[v][6:0]))
                                            : (M+1)'(int'(VEC[v][6:0]));
         step();
         if (VEC[v][29] != VEC[v][28]) check("R2 table magnitudes", 128'(upd_mag), 128'(em));
         else check("R3 table magnitudes", 128'(upd_mag), 128'(em));
         check("R4 table decisions", 128'(upd_dec[E-1:B]), 128'({(E-B){VEC[v][29]}}));
         check("R5 newest entry", 128'({upd_dec[B-1:0], upd_mag[B*M-1:0]}),
               128'({new_dec, new_mag}));
         check("R6 table llr", 128'({out_valid, out_llr}), 128'({1'b1, el}));
      end

      // R6: sign per bit, mixed decisions at the oldest position
      randomize_inputs();
      win_dec[E-B] = 1'b1; win_dec[E-B+1] = 1'b0;
      sec_dec[E-B] = 1'b0; sec_dec[E-B+1] = 1'b1;
      win_mag[(E-B)*M +: M] = 7'd100; win_mag[(E-B+1)*M +: M] = 7'd100;
      dec_rel = 7'd40;
      predict();
      step();
      check("R6 mixed sign llr", 128'(out_llr), 128'({8'd40, 8'hD8}));

      // R7: idle cycle keeps everything
      sv_dec = upd_dec; sv_mag = upd_mag; sv_llr = out_llr;
      in_valid = 1'b0;
      randomize_inputs();
      step();
      check("R7 hold", 128'({upd_dec, out_llr}), 128'({sv_dec, sv_llr}));
      check("R7 hold magnitudes", 128'(upd_mag), 128'(sv_mag));
      check("R6 out_valid low after idle", 128'(out_valid), 128'(0));

      // Random histories against the model.
      for (int r = 0; r < 400; r++) begin
         randomize_inputs();
         if (r % 4 == 0) begin
            for (int k = 0; k < E; k++) sec_dec[k] = win_dec[k];
            dec_rel = M'($urandom_range(MX - 30, MX));
         end
         in_valid = 1'b1;
         predict();
         step();
         check("R8 layout with R2 R3 magnitudes", 128'(upd_mag), 128'(exp_mag));
         check("R4 random decisions", 128'(upd_dec), 128'(exp_dec));
         check("R6 random llr", 128'({out_valid, out_llr}), 128'({1'b1, exp_llr}));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule